// File: doc/BRIEF.md
# LCD Operating Clock Generator

This block derives the operating clock of an LCD driver from one of two oscillators. Both oscillators reach the block as single-cycle tick strobes that are synchronous to the system clock. A small configuration register selects which oscillator is used, sets the division ratio for the fast oscillator and gates the result with an enable bit. The block produces a one-system-cycle tick at the end of each divide period. It also produces a level output that toggles on every tick, which gives a clock with 50% duty.

The slow, 32 kHz-class oscillator always runs through a fixed divide-by-64. The fast oscillator runs through a power-of-two divider that software selects. When the enable is cleared, or a reserved source code is selected, the output stops and the divide counter is held at zero. The next enable therefore starts a full, clean period. The division ratio is locked while the enable is set. A write that tries to change it during that time is dropped and raises an error flag.

Top module: `lcd_clkgen`

## Requirements
- R1: After reset the source code, divide code, enable and error flag read 0, and `lclk_tick` and `lclk_out` are low.
- R2: With source code 0 (fast oscillator), one output tick is produced every 1024 << D fast-oscillator ticks, where D is the divide code (0..3). This gives ratios of 1024, 2048, 4096 and 8192.
- R3: With source code 1 (slow oscillator), one output tick is produced every 64 slow-oscillator ticks, whatever the divide code holds.
- R4: While the enable is 0, no output tick appears, `lclk_out` is low and the divide counter is held at zero. After the enable is set, the first tick comes exactly one full period of selected source ticks later.
- R5: Source codes 2 and 3 are reserved. With either code selected, no tick appears and `lclk_out` stays low, even when the enable is 1.
- R6: While the enable is 0, a write updates the source code and the divide code, and the written values read back on the next cycle.
- R7: A write made while the enable is 1 leaves the divide code unchanged if it carries a different divide code, and sets the error flag. A write that leaves the divide code intact and carries enable 0 clears the error flag.
- R8: `lclk_tick` is high for exactly one system cycle per period. `lclk_out` inverts in the same cycle as each tick, so its first high phase after enabling starts with the first tick.
- R9: Ticks from the oscillator that is not selected do not advance the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_hs_tick | input | 1 | Fast oscillator tick strobe |
| osc_ls_tick | input | 1 | Slow oscillator tick strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wsrc | input | 2 | Source code to write (0 fast, 1 slow, 2/3 reserved) |
| cfg_wdiv | input | 2 | Divide code to write (fast oscillator ratio) |
| cfg_wen | input | 1 | Enable value to write |
| cfg_src | output | 2 | Current source code |
| cfg_div | output | 2 | Current divide code |
| cfg_en | output | 1 | Current enable |
| cfg_err | output | 1 | Sticky flag: rejected divide-code change |
| lclk_tick | output | 1 | One-cycle tick per LCD clock period |
| lclk_out | output | 1 | 50% duty LCD clock level |

## Verification
The bench measures the latency from enable to the first tick, and the spacing between ticks, for every divide code. It does this while the unselected oscillator keeps ticking. A divider with a wrong shift, a counter that is not cleared on disable, or a mux that listens to the wrong oscillator all produce a count that differs from the expected period. The bench holds the block disabled, and then enabled with reserved source codes. A gate that is missing shows up as stray ticks. The bench tries to change the ratio while the block runs. If the lock is missing, the period changes or the divide code reads back new, and if the flag logic is faulty, the flag fails to rise or fails to clear.

// File: rtl/lcd_clkgen_pkg.sv
// Shared types for the LCD clock generator.
// Assumes 2-bit source and divide fields.
package lcd_clkgen_pkg;

    typedef enum logic [1:0] {
        SRC_FAST  = 2'd0,
        SRC_SLOW  = 2'd1,
        SRC_RSV_A = 2'd2,
        SRC_RSV_B = 2'd3
    } src_sel_e;

    // Reserved codes have the upper bit set
    function automatic logic src_is_valid(input logic [1:0] code);
        return !code[1];
    endfunction

endpackage

// File: rtl/lcd_clkgen_regs.sv
// Configuration register for the LCD clock generator.
// Holds source, divide code, enable and a sticky lock-violation flag.
// Assumes a write strobe carries all fields at once.
module lcd_clkgen_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] wsrc,
    input  logic [1:0] wdiv,
    input  logic       wen,
    output logic [1:0] src_q,
    output logic [1:0] div_q,
    output logic       en_q,
    output logic       err_q
);

    logic div_locked;

    // Divide change attempted while running
    always_comb begin
        div_locked = en_q && (wdiv != div_q);
    end

    // Register update with the divide lock and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= 2'd0;
            div_q <= 2'd0;
            en_q  <= 1'b0;
            err_q <= 1'b0;
        end else if (wr) begin
            src_q <= wsrc;
            en_q  <= wen;
            if (div_locked) begin
                err_q <= 1'b1;
            end else begin
                div_q <= wdiv;
                if (!wen) begin
                    err_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/lcd_clkgen_div.sv
// Source selection and period counter.
// Counts the ticks of the selected oscillator. It flags the last tick
// of each period on hit (combinational, same cycle as that tick).
// Assumes LS_LOG2 <= HS_LOG2 + 3 so both terminals fit the counter.
module lcd_clkgen_div #(
    parameter int HS_LOG2 = 10,
    parameter int LS_LOG2 = 6,
    parameter int CW      = HS_LOG2 + 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hs_tick,
    input  logic       ls_tick,
    input  logic [1:0] src,
    input  logic [1:0] div,
    input  logic       en,
    output logic       active,
    output logic       hit
);
    import lcd_clkgen_pkg::*;

    localparam int NDIV = 4;

    logic [CW-1:0] hs_term [NDIV];
    logic [CW-1:0] ls_term;
    logic [CW-1:0] term;
    logic [CW-1:0] cnt;
    logic          src_tick;

    // One terminal count per fast-oscillator ratio
    for (genvar i = 0; i < NDIV; i++) begin : g_term
        assign hs_term[i] = CW'((64'd1 << (HS_LOG2 + i)) - 64'd1);
    end
    assign ls_term = CW'((64'd1 << LS_LOG2) - 64'd1);

    // Pick the source strobe and its terminal count
    always_comb begin
        active   = en && src_is_valid(src);
        src_tick = (src == SRC_SLOW) ? ls_tick : hs_tick;
        term     = (src == SRC_SLOW) ? ls_term : hs_term[div];
        hit      = active && src_tick && (cnt >= term);
    end

    // Period counter, held at zero while inactive
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt <= '0;
        end else if (src_tick) begin
            cnt <= (cnt >= term) ? '0 : cnt + CW'(1);
        end
    end

endmodule

// File: rtl/lcd_clkgen_out.sv
// Output stage: registers the period tick and the toggled clock level.
// The level is forced low while the generator is inactive.
module lcd_clkgen_out (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic hit,
    output logic tick_q,
    output logic lvl_q
);

    // Tick and level registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
            lvl_q  <= 1'b0;
        end else begin
            tick_q <= hit;
            lvl_q  <= active ? (lvl_q ^ hit) : 1'b0;
        end
    end

endmodule

// File: rtl/lcd_clkgen.sv
// LCD operating clock generator top.
// Oscillators arrive as tick strobes in the clk domain.
// Source 0 divides by 1024<<div, source 1 by 64, and sources 2/3 are stopped.
module lcd_clkgen #(
    parameter int HS_LOG2 = 10,
    parameter int LS_LOG2 = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_hs_tick,
    input  logic       osc_ls_tick,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_wsrc,
    input  logic [1:0] cfg_wdiv,
    input  logic       cfg_wen,
    output logic [1:0] cfg_src,
    output logic [1:0] cfg_div,
    output logic       cfg_en,
    output logic       cfg_err,
    output logic       lclk_tick,
    output logic       lclk_out
);

    localparam int CW = HS_LOG2 + 3;

    logic active;
    logic hit;

    lcd_clkgen_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wsrc  (cfg_wsrc),
        .wdiv  (cfg_wdiv),
        .wen   (cfg_wen),
        .src_q (cfg_src),
        .div_q (cfg_div),
        .en_q  (cfg_en),
        .err_q (cfg_err)
    );

    lcd_clkgen_div #(
        .HS_LOG2 (HS_LOG2),
        .LS_LOG2 (LS_LOG2),
        .CW      (CW)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .hs_tick (osc_hs_tick),
        .ls_tick (osc_ls_tick),
        .src     (cfg_src),
        .div     (cfg_div),
        .en      (cfg_en),
        .active  (active),
        .hit     (hit)
    );

    lcd_clkgen_out u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .hit    (hit),
        .tick_q (lclk_tick),
        .lvl_q  (lclk_out)
    );

endmodule

// File: rtl/lcd_clkgen_chk.sv
// Assertion checker for lcd_clkgen, attached to it with bind.
module lcd_clkgen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [1:0] cfg_wsrc,
    input logic [1:0] cfg_wdiv,
    input logic [1:0] cfg_src,
    input logic [1:0] cfg_div,
    input logic       cfg_en,
    input logic       cfg_err,
    input logic       lclk_tick,
    input logic       lclk_out
);

    a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!lclk_tick && !lclk_out));

    a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_src[1] |=> !lclk_tick);

    a_r6_write_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_en) |=> (cfg_div == $past(cfg_wdiv) && cfg_src == $past(cfg_wsrc)));

    a_r7_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_en && (cfg_wdiv != cfg_div)) |=> (cfg_err && cfg_div == $past(cfg_div)));

    a_r8_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        lclk_tick |=> !lclk_tick);

    a_r8_level_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        lclk_tick |-> (lclk_out != $past(lclk_out)));

endmodule

bind lcd_clkgen lcd_clkgen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wsrc  (cfg_wsrc),
    .cfg_wdiv  (cfg_wdiv),
    .cfg_src   (cfg_src),
    .cfg_div   (cfg_div),
    .cfg_en    (cfg_en),
    .cfg_err   (cfg_err),
    .lclk_tick (lclk_tick),
    .lclk_out  (lclk_out)
);

// File: tb/lcd_clkgen_tb.sv
// Self-checking bench for lcd_clkgen: a vector table of source/ratio
// settings with measured tick spacing, then directed corner cases.
module lcd_clkgen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_hs_tick = 1'b0;
    logic       osc_ls_tick = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_wsrc = 2'd0;
    logic [1:0] cfg_wdiv = 2'd0;
    logic       cfg_wen = 1'b0;
    logic [1:0] cfg_src;
    logic [1:0] cfg_div;
    logic       cfg_en;
    logic       cfg_err;
    logic       lclk_tick;
    logic       lclk_out;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int hs_gap = 0;
    int ls_gap = 0;
    int hs_ph = 0;
    int ls_ph = 0;
    bit done = 1'b0;

    // Vector table: source, divide, fast gap, slow gap, expected period in cycles
    localparam int NV = 7;
    localparam int VS [NV] = '{0, 0, 0, 0, 1, 1, 0};
    localparam int VD [NV] = '{0, 1, 2, 3, 0, 3, 0};
    localparam int VHG[NV] = '{1, 1, 1, 1, 1, 1, 2};
    localparam int VLG[NV] = '{3, 3, 3, 3, 3, 3, 1};
    localparam int VP [NV] = '{1024, 2048, 4096, 8192, 192, 192, 2048};

    lcd_clkgen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_hs_tick (osc_hs_tick),
        .osc_ls_tick (osc_ls_tick),
        .cfg_wr      (cfg_wr),
        .cfg_wsrc    (cfg_wsrc),
        .cfg_wdiv    (cfg_wdiv),
        .cfg_wen     (cfg_wen),
        .cfg_src     (cfg_src),
        .cfg_div     (cfg_div),
        .cfg_en      (cfg_en),
        .cfg_err     (cfg_err),
        .lclk_tick   (lclk_tick),
        .lclk_out    (lclk_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Oscillator strobes, one every gap cycles (gap 0 = silent)
    always @(negedge clk) begin
        hs_ph = (hs_ph + 1 >= hs_gap) ? 0 : hs_ph + 1;
        ls_ph = (ls_ph + 1 >= ls_gap) ? 0 : ls_ph + 1;
        osc_hs_tick = (hs_gap != 0) && (hs_ph == 0);
        osc_ls_tick = (ls_gap != 0) && (ls_ph == 0);
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int s, input int d, input int e);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_wsrc = 2'(s);
        cfg_wdiv = 2'(d);
        cfg_wen  = (e != 0);
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    // Wait for the next tick; returns its cycle number or -1 on timeout
    task automatic wait_tick(output int t);
        t = -1;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (lclk_tick) begin
                t = cyc;
                break;
            end
        end
    endtask

    // Count ticks and high levels over n cycles
    task automatic watch(input int n, output int ticks, output int highs);
        ticks = 0;
        highs = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ticks += int'(lclk_tick);
            highs += int'(lclk_out);
        end
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int t0, t1, t2, t3, nt, nh;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 src", int'(cfg_src), 0);
        check("R1 div", int'(cfg_div), 0);
        check("R1 en", int'(cfg_en), 0);
        check("R1 err", int'(cfg_err), 0);
        check("R1 tick", int'(lclk_tick), 0);
        check("R1 out", int'(lclk_out), 0);
        rst_n = 1'b1;

        // Vector table walk: R2, R3, R4, R8, R9
        for (int i = 0; i < NV; i++) begin
            write_cfg(int'(cfg_src), int'(cfg_div), 0);
            hs_gap = VHG[i];
            ls_gap = VLG[i];
            write_cfg(VS[i], VD[i], 0);
            write_cfg(VS[i], VD[i], 1);
            t0 = cyc;
            wait_tick(t1);
            if (VHG[i] == 1 && VS[i] == 0)
                check("R4 first tick latency", t1 - t0, VP[i]);
            check("R8 level after first tick", int'(lclk_out), 1);
            wait_tick(t2);
            check(VS[i] == 0 ? "R2 period" : "R3 period", t2 - t1, VP[i]);
            check("R8 level after second tick", int'(lclk_out), 0);
            wait_tick(t3);
            check(VS[i] == 0 ? "R2 R9 period" : "R3 R9 period", t3 - t2, VP[i]);
        end

        // R4: disabled with both oscillators running fast
        hs_gap = 1;
        ls_gap = 1;
        write_cfg(0, 0, 0);
        watch(3000, nt, nh);
        check("R4 no tick while off", nt, 0);
        check("R4 level low while off", nh, 0);

        // R6: config writable and readable while off
        write_cfg(1, 2, 0);
        check("R6 src readback", int'(cfg_src), 1);
        check("R6 div readback", int'(cfg_div), 2);
        check("R6 en readback", int'(cfg_en), 0);

        // R5: reserved source codes stay silent when enabled
        write_cfg(2, 2, 1);
        watch(3000, nt, nh);
        check("R5 code 2 ticks", nt, 0);
        check("R5 code 2 level", nh, 0);
        write_cfg(3, 2, 1);
        watch(3000, nt, nh);
        check("R5 code 3 ticks", nt, 0);
        check("R5 code 3 level", nh, 0);

        // R7: divide change while running is rejected and flagged
        write_cfg(3, 2, 0);
        write_cfg(0, 0, 0);
        write_cfg(0, 0, 1);
        write_cfg(0, 3, 1);
        check("R7 div unchanged", int'(cfg_div), 0);
        check("R7 err set", int'(cfg_err), 1);
        wait_tick(t1);
        wait_tick(t2);
        check("R7 period unchanged", t2 - t1, 1024);
        write_cfg(0, 0, 0);
        check("R7 err cleared", int'(cfg_err), 0);
        write_cfg(0, 3, 0);
        check("R7 div accepted when off", int'(cfg_div), 3);
        check("R7 err stays clear", int'(cfg_err), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule